// File: doc/BRIEF.md
# Segmented Write Target Adapter with Two Delivery Ports

This block sits on the target side of a simple peripheral bus whose data path is one byte wide. It turns a stream of byte writes back into whole words for two attached input ports of an IP core. One port is 64 bits wide and the other is 32 bits wide. Each bus address carries a port-select bit and a byte index. The adapter steers each byte into a staging buffer for the chosen port. When the byte that completes a word arrives, the whole word moves to that port's output in one step.

Each port is built, through a parameter, with one of two delivery styles. A latest-value port never holds up the bus: it always shows the last finished word, and a newer word replaces it. A queued-handoff port keeps a finished word until the consumer takes it. While that word is still pending, the bus write that would finish the next word is held without acknowledge. Read commands are acknowledged at once and return zero.

Top module: `wta_target`

## Requirements
- R1: Address bit 3 selects the destination: 0 targets the 64-bit port and 1 targets the 32-bit port. Address bit 4 is ignored.
- R2: Address bits [2:0] give the byte index i. A byte written with index i lands in bits [8i+7:8i] of the selected port's word.
- R3: A word is complete when its highest index is written: 7 for the 64-bit port and 3 for the 32-bit port. At the next clock edge the port word shows all bytes staged so far, including that last byte.
- R4: The 64-bit port uses latest-value delivery. Its valid output stays high from the first completed word onward. Each new word overwrites the previous one, and its take input has no effect.
- R5: The 32-bit port uses queued-handoff delivery. Its valid output rises when a word completes and falls at the clock edge where take is high while valid is high. Its word stays unchanged while valid is high and take is low.
- R6: While the 32-bit port's valid is high, a write to index 3 of that port gets no acknowledge, and the write is not applied. The acknowledge first appears in the cycle after a take has cleared valid. Writes to indices 0 to 2 are acknowledged throughout.
- R7: A write to the 32-bit port with index 4 to 7 is acknowledged and changes nothing.
- R8: A read command (bus_rnw high) is acknowledged in the same cycle, with bus_rdata equal to zero.
- R9: After reset, both valid outputs are low and both port words are zero.
- R10: bus_ack is high only when bus_val is high. It is high in the same cycle as bus_val unless R6 withholds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_val | input | 1 | Command valid |
| bus_rnw | input | 1 | 1 = read command, 0 = write command |
| bus_addr | input | 5 | Bits [2:0] are the byte index, bit 3 is the port select, bit 4 is ignored |
| bus_wdata | input | 8 | Write byte |
| bus_ack | output | 1 | Command accepted in this cycle |
| bus_rdata | output | 8 | Read data, always zero |
| p0_word | output | 64 | Word delivered to the 64-bit port |
| p0_valid | output | 1 | 64-bit port holds a word |
| p0_take | input | 1 | Consumer take for the 64-bit port (ignored in latest-value mode) |
| p1_word | output | 32 | Word delivered to the 32-bit port |
| p1_valid | output | 1 | 32-bit port holds an unconsumed word |
| p1_take | input | 1 | Consumer take for the 32-bit port |

## Verification
The hardest case to reach is a finishing write that arrives at the queued port while the previous word is still pending, with the take landing while that write is held. Only then do the withheld acknowledge and its release one cycle after the take both show up. The stimulus fills the 32-bit port, leaves take low while it writes the lower bytes of a second word, and holds the finishing write for several cycles. It then raises take in the middle of that hold. Long random traffic follows, mixing takes, reads, out-of-range indices and agent-bit values, against a bench model of both ports.

// File: rtl/wta_pkg.sv
package wta_pkg;

   typedef enum logic {
      DELIV_LATEST = 1'b0,
      DELIV_QUEUED = 1'b1
   } deliv_e;

endpackage

// File: rtl/wta_decode.sv
module wta_decode #(
   parameter int IDX_W = 3
) (
   input  logic             cmd_val,
   input  logic             cmd_rnw,
   input  logic [IDX_W:0]   cmd_addr,
   output logic             wr_req,
   output logic             port_sel,
   output logic [IDX_W-1:0] seg_idx
);

   // The field above the index picks the port; the index is the low field.
   assign wr_req   = cmd_val & ~cmd_rnw;
   assign port_sel = cmd_addr[IDX_W];
   assign seg_idx  = cmd_addr[IDX_W-1:0];

endmodule

// File: rtl/wta_lane.sv
module wta_lane
   import wta_pkg::*;
#(
   parameter int     SEG_W = 8,
   parameter int     NSEG  = 8,
   parameter int     IDX_W = 3,
   parameter deliv_e MODE  = DELIV_LATEST
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit,
   input  logic [IDX_W-1:0]   idx,
   input  logic [SEG_W-1:0]   seg,
   input  logic               ack,
   input  logic               take,
   output logic               stall,
   output logic [SEG_W*NSEG-1:0] word,
   output logic               valid
);

   localparam int WORD_W = SEG_W * NSEG;
   localparam int TOP    = NSEG - 1;
   localparam logic [IDX_W:0]   NSEG_V = IDX_W'(0) + (IDX_W+1)'(NSEG);
   localparam logic [IDX_W-1:0] TOP_V  = IDX_W'(TOP);

   initial begin
      assert (NSEG >= 2 && NSEG <= (1 << IDX_W))
         else $error("wta_lane: NSEG must lie in 2..2**IDX_W");
   end

   logic                           in_range;
   logic                           is_top;
   logic                           req;
   logic                           accept;
   logic [NSEG-2:0][SEG_W-1:0]     part_q;
   logic [WORD_W-1:0]              word_q;
   logic                           valid_q;

   assign in_range = {1'b0, idx} < NSEG_V;
   assign is_top   = in_range && (idx == TOP_V);
   assign req      = hit & in_range;
   assign accept   = req & ack;

   // Staging registers for every segment below the top one.
   for (genvar i = 0; i < NSEG - 1; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            part_q[i] <= '0;
         else if (accept && idx == IDX_W'(i))
            part_q[i] <= seg;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (accept && is_top)
         word_q <= {seg, part_q};
   end

   if (MODE == DELIV_QUEUED) begin : g_queued
      assign stall = req & is_top & valid_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            valid_q <= 1'b0;
         else if (accept && is_top)
            valid_q <= 1'b1;
         else if (take)
            valid_q <= 1'b0;
      end

      assert_fifo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_q && !take) |=> (valid_q && $stable(word_q)))
         else $error("queued word changed before consumption");
   end else begin : g_latest
      logic unused_take;
      assign unused_take = take;
      assign stall       = 1'b0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            valid_q <= 1'b0;
         else if (accept && is_top)
            valid_q <= 1'b1;
      end

      assert_sticky_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q |=> valid_q)
         else $error("latest-value port lost its word");
   end

   assert_word_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_top) |=> valid_q)
      else $error("completed word not presented");

   assign word  = word_q;
   assign valid = valid_q;

endmodule

// File: rtl/wta_target.sv
module wta_target
   import wta_pkg::*;
#(
   parameter int     SEG_W   = 8,
   parameter int     ADDR_W  = 5,
   parameter int     IDX_W   = 3,
   parameter int     P0_SEGS = 8,
   parameter int     P1_SEGS = 4,
   parameter deliv_e P0_MODE = DELIV_LATEST,
   parameter deliv_e P1_MODE = DELIV_QUEUED
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_val,
   input  logic                     bus_rnw,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [SEG_W-1:0]         bus_wdata,
   output logic                     bus_ack,
   output logic [SEG_W-1:0]         bus_rdata,
   output logic [SEG_W*P0_SEGS-1:0] p0_word,
   output logic                     p0_valid,
   input  logic                     p0_take,
   output logic [SEG_W*P1_SEGS-1:0] p1_word,
   output logic                     p1_valid,
   input  logic                     p1_take
);

   localparam int FIELD_W = IDX_W + 1;

   initial begin
      assert (ADDR_W > FIELD_W)
         else $error("wta_target: address must hold agent, port and index fields");
   end

   logic             wr_req;
   logic             port_sel;
   logic [IDX_W-1:0] seg_idx;
   logic             stall0;
   logic             stall1;
   logic             unused_agent;

   // Agent-number bits are consumed by the network, not here.
   assign unused_agent = ^bus_addr[ADDR_W-1:FIELD_W];

   wta_decode #(.IDX_W(IDX_W)) u_dec (
      .cmd_val  (bus_val),
      .cmd_rnw  (bus_rnw),
      .cmd_addr (bus_addr[FIELD_W-1:0]),
      .wr_req   (wr_req),
      .port_sel (port_sel),
      .seg_idx  (seg_idx)
   );

   assign bus_ack   = bus_val & ~stall0 & ~stall1;
   assign bus_rdata = '0;

   wta_lane #(.SEG_W(SEG_W), .NSEG(P0_SEGS), .IDX_W(IDX_W), .MODE(P0_MODE)) u_lane0 (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (wr_req & ~port_sel),
      .idx   (seg_idx),
      .seg   (bus_wdata),
      .ack   (bus_ack),
      .take  (p0_take),
      .stall (stall0),
      .word  (p0_word),
      .valid (p0_valid)
   );

   wta_lane #(.SEG_W(SEG_W), .NSEG(P1_SEGS), .IDX_W(IDX_W), .MODE(P1_MODE)) u_lane1 (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (wr_req & port_sel),
      .idx   (seg_idx),
      .seg   (bus_wdata),
      .ack   (bus_ack),
      .take  (p1_take),
      .stall (stall1),
      .word  (p1_word),
      .valid (p1_valid)
   );

   assert_ack_needs_val_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |-> bus_val)
      else $error("acknowledge without command");

   assert_stall_reason_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_val && !bus_rnw && !bus_ack) |-> (p0_valid || p1_valid))
      else $error("write withheld with no pending word");

endmodule

// File: tb/tb_wta_target.sv
`timescale 1ns/1ps
module tb_wta_target;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_val = 1'b0;
   logic        bus_rnw = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_ack;
   logic [7:0]  bus_rdata;
   logic [63:0] p0_word;
   logic        p0_valid;
   logic        p0_take = 1'b0;
   logic [31:0] p1_word;
   logic        p1_valid;
   logic        p1_take = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic last_ack;

   // Behavioural model state
   logic [63:0] m_buf0 = '0, m_word0 = '0;
   logic [31:0] m_buf1 = '0, m_word1 = '0;
   logic        m_val0 = 1'b0, m_val1 = 1'b0;

   always #2.5 clk = ~clk;

   wta_target dut (
      .clk(clk), .rst_n(rst_n), .bus_val(bus_val), .bus_rnw(bus_rnw),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_rdata(bus_rdata), .p0_word(p0_word), .p0_valid(p0_valid),
      .p0_take(p0_take), .p1_word(p1_word), .p1_valid(p1_valid),
      .p1_take(p1_take)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic model_ack();
      int idx;
      logic req1;
      idx  = int'(bus_addr[2:0]);
      req1 = bus_val && !bus_rnw && bus_addr[3] && idx < 4;
      return bus_val && !(req1 && idx == 3 && m_val1);
   endfunction

   task automatic cyc(input logic v, input logic r, input logic [4:0] a,
                      input logic [7:0] d, input logic t0, input logic t1);
      logic ea;
      int idx;
      @(negedge clk);
      bus_val = v; bus_rnw = r; bus_addr = a; bus_wdata = d;
      p0_take = t0; p1_take = t1;
      #1;
      ea = model_ack();
      last_ack = bus_ack;
      chk("R10", {63'd0, bus_ack}, {63'd0, ea});
      if (v && r) chk("R8", {56'd0, bus_rdata}, 64'd0);
      @(posedge clk);
      #1;
      if (t1 && m_val1) m_val1 = 1'b0;
      idx = int'(a[2:0]);
      if (v && !r && ea) begin
         if (!a[3]) begin
            if (idx == 7) begin
               m_word0 = {d, m_buf0[55:0]};
               m_val0  = 1'b1;
            end else m_buf0[idx*8 +: 8] = d;
         end else if (idx < 4) begin
            if (idx == 3) begin
               m_word1 = {d, m_buf1[23:0]};
               m_val1  = 1'b1;
            end else m_buf1[idx*8 +: 8] = d;
         end
      end
      chk("R2", p0_word, m_word0);
      chk("R4", {63'd0, p0_valid}, {63'd0, m_val0});
      chk("R3", {32'd0, p1_word}, {32'd0, m_word1});
      chk("R5", {63'd0, p1_valid}, {63'd0, m_val1});
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      cyc(1'b1, 1'b0, a, d, 1'b0, 1'b0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", {63'd0, p0_valid}, 64'd0);
      chk("R9", {63'd0, p1_valid}, 64'd0);
      chk("R9", p0_word, 64'd0);
      chk("R9", {32'd0, p1_word}, 64'd0);
      rst_n = 1'b1;

      // R2/R3: 64-bit word, indices out of order, top index last
      for (int i = 6; i >= 0; i--) wr(5'(i), 8'h10 + 8'(i));
      chk("R3", {63'd0, p0_valid}, 64'd0);
      wr(5'd7, 8'h17);
      chk("R2", p0_word, 64'h1716151413121110);

      // R1: 32-bit port with agent bit set
      for (int i = 0; i < 4; i++) wr(5'b11000 | 5'(i), 8'hA0 + 8'(i));
      chk("R1", {32'd0, p1_word}, 64'h00000000A3A2A1A0);
      chk("R5", {63'd0, p1_valid}, 64'd1);

      // R7: out-of-range index on 32-bit port
      wr(5'b01101, 8'hEE);
      chk("R7", {63'd0, last_ack}, 64'd1);
      chk("R7", {32'd0, p1_word}, 64'h00000000A3A2A1A0);

      // R6: completing write held while previous word pending
      for (int i = 0; i < 3; i++) begin
         wr(5'b01000 | 5'(i), 8'hB0 + 8'(i));
         chk("R6", {63'd0, last_ack}, 64'd1);
      end
      wr(5'b01011, 8'hB3);
      chk("R6", {63'd0, last_ack}, 64'd0);
      wr(5'b01011, 8'hB3);
      chk("R6", {63'd0, last_ack}, 64'd0);
      chk("R5", {32'd0, p1_word}, 64'h00000000A3A2A1A0);
      cyc(1'b1, 1'b0, 5'b01011, 8'hB3, 1'b0, 1'b1);
      chk("R6", {63'd0, last_ack}, 64'd0);
      chk("R5", {63'd0, p1_valid}, 64'd0);
      wr(5'b01011, 8'hB3);
      chk("R6", {63'd0, last_ack}, 64'd1);
      chk("R6", {32'd0, p1_word}, 64'h00000000B3B2B1B0);

      // R4: overwrite on latest-value port, take ignored
      cyc(1'b1, 1'b0, 5'd0, 8'h55, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 5'd7, 8'h99, 1'b1, 1'b0);
      chk("R4", p0_word, 64'h9916151413121155);
      chk("R4", {63'd0, p0_valid}, 64'd1);

      // R8: read command
      cyc(1'b1, 1'b1, 5'b01011, 8'h00, 1'b0, 1'b0);
      chk("R8", {63'd0, last_ack}, 64'd1);

      // Random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         cyc(1'($urandom), ($urandom % 8) == 0, 5'($urandom), 8'($urandom),
             1'($urandom), ($urandom % 4) == 0);
      end

      done = 1'b1;
      finish_run();
   end

endmodule